// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the byte-wide register front end of an asynchronous serial controller. A host bus presents a 3-bit offset with read and write strobes. The block holds the control registers and drives framing, modem-control, FIFO-control and baud-divisor settings to the transmitter, the receiver and the FIFOs. It collects their status into the line status and modem status views and raises a single interrupt line.

Reads return data combinationally in the cycle the read strobe is high. Writes and the clear-on-read side effects take effect at the clock edge that ends that cycle. One bit of the line control register opens a second bank on offsets 0 and 1 for the 16-bit baud divisor. Offset 2 is split: a read returns the interrupt identity and a write goes to FIFO control.

Top module: `serial_regfile`

## Requirements
- R1: After reset, line control, interrupt enable, modem control, FIFO control and divisor are all 0, the identity register reads 0x01 and `irq` is low.
- R2: With line control bit 7 clear, a write to offset 0 pulses `tx_write` with `tx_byte` equal to the written byte. A read of offset 0 returns `rx_byte` and pulses `rx_pop`. Offset 1 reads and writes the enable register: bit0 receive data, bit1 transmit empty, bit2 line status, bit3 modem status; bits 7:4 read 0.
- R3: With line control bit 7 set, offset 0 accesses divisor bits 7:0 and offset 1 accesses divisor bits 15:8. In this mode `tx_write` and `rx_pop` stay low and the enable register is unchanged.
- R4: A write to offset 2 updates `fifo_cfg` with bits 7:3 and bit 0 kept and bits 2:1 read as 0. Written bit 1 pulses `rx_flush` and written bit 2 pulses `tx_flush`. A read of offset 2 returns the identity value, whose bits 7:6 both equal FIFO enable (`fifo_cfg[0]`).
- R5: Offset 3 (line control) reads back all 8 bits, and `frame_cfg` equals bits 6:0. Offset 4 (modem control) keeps bits 5:0, which drive `modem_ctl`; bits 7:6 read 0.
- R6: Offset 5 reads {0, `tx_idle`, `thr_empty`, break, framing, parity, overrun, `rx_ready`}. The four error bits latch on `err_evt[3:0]` pulses (index 0 = overrun … 3 = break) and clear when offset 5 is read. An event in the same cycle as that read is kept for the next read.
- R7: Offset 6 reads {line state[3:0], change flags[3:0]}. The line state is `line_in` registered once. A change flag is set when its line differs from its registered copy, and all change flags clear when offset 6 is read.
- R8: The identity low 3 bits report the highest-priority enabled pending source. In priority order these are line error 110, receive data 100, transmit empty 010 and modem change 000. If nothing is pending they report 001.
- R9: The transmit-empty source becomes pending when `thr_empty` rises, or when enable bit 1 is written from 0 to 1 while `thr_empty` is high. It is cleared by a transmit write, or by a read of offset 2 that reports it.
- R10: `irq` is high exactly when any enabled source is pending.
- R11: Offset 7 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| irq | output | 1 | Interrupt request |
| tx_write | output | 1 | Pulse: byte to transmitter |
| tx_byte | output | 8 | Byte to transmitter |
| rx_pop | output | 1 | Pulse: receive byte consumed |
| rx_byte | input | 8 | Head receive byte |
| rx_ready | input | 1 | Receive data available |
| thr_empty | input | 1 | Transmit holding empty |
| tx_idle | input | 1 | Transmitter fully empty |
| err_evt | input | 4 | Error pulses: overrun, parity, framing, break |
| line_in | input | 4 | Modem lines: CTS, DSR, RI, DCD |
| divisor | output | 16 | Baud divisor |
| frame_cfg | output | 7 | Framing configuration |
| modem_ctl | output | 6 | Modem control outputs |
| fifo_cfg | output | 8 | FIFO configuration |
| rx_flush | output | 1 | Pulse: clear receive FIFO |
| tx_flush | output | 1 | Pulse: clear transmit FIFO |

## Verification
The bench sweeps every line control, modem control and enable value, and walks the divisor through both banks. It checks that the bank switch never leaks a transmit pulse or a receive pop, which would corrupt the data stream during baud setup. The interrupt sweep holds all four sources pending under every enable mask. A wrong priority order would report a lower source first and starve line errors. Clear-on-read is tested with an error arriving in the same cycle as the status read; a design that lets the clear win loses that error silently. The transmit-empty source is cleared by reading the identity and then re-armed by a rising empty, which catches both a sticky and a never-set flag.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;
    localparam int SRC_N  = 4;
    localparam int ERR_N  = 4;

    localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_ENA   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_IDFC  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_LINE  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_MODEM = 3'd4;
    localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;

    localparam logic [2:0] ID_NONE  = 3'b001;
    localparam logic [2:0] ID_LSTAT = 3'b110;
    localparam logic [2:0] ID_RXDAT = 3'b100;
    localparam logic [2:0] ID_TXEMP = 3'b010;
    localparam logic [2:0] ID_MSTAT = 3'b000;

    typedef struct packed {
        logic [BYTE_W-1:0]   lcr;
        logic [SRC_N-1:0]    ier;
        logic [5:0]          mcr;
        logic [BYTE_W-1:0]   fcr;
        logic [2*BYTE_W-1:0] div;
        logic                thre_pend;
        logic                thr_empty_q;
    } ctl_t;

endpackage

// File: rtl/sr_irq_prio.sv
module sr_irq_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0]      req,
    input  logic [N-1:0][2:0] codes,
    input  logic [2:0]        idle_code,
    output logic [2:0]        id
);
    // index 0 is the highest priority, so it is applied last
    always_comb begin
        id = idle_code;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) id = codes[i];
        end
    end
endmodule

// File: rtl/sr_line_status.sv
module sr_line_status #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             clr_rd,
    input  logic             rx_ready,
    input  logic             thr_empty,
    input  logic             tx_idle,
    output logic [7:0]       lsr
);
    logic [ERR_W-1:0] err_d, err_q;

    always_comb begin
        err_d = (clr_rd ? '0 : err_q) | err_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign lsr = {1'b0, tx_idle, thr_empty, err_q, rx_ready};
endmodule

// File: rtl/sr_modem_status.sv
module sr_modem_status #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic             clr_rd,
    output logic [2*LINES-1:0] msr
);
    typedef struct packed {
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] chg;
    } mst_t;

    mst_t st_d, st_q;

    always_comb begin
        st_d.lvl = line_in;
        st_d.chg = (clr_rd ? '0 : st_q.chg) | (line_in ^ st_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msr = {st_q.lvl, st_q.chg};
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
    import serial_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        irq,
    output logic        tx_write,
    output logic [7:0]  tx_byte,
    output logic        rx_pop,
    input  logic [7:0]  rx_byte,
    input  logic        rx_ready,
    input  logic        thr_empty,
    input  logic        tx_idle,
    input  logic [3:0]  err_evt,
    input  logic [3:0]  line_in,
    output logic [15:0] divisor,
    output logic [6:0]  frame_cfg,
    output logic [5:0]  modem_ctl,
    output logic [7:0]  fifo_cfg,
    output logic        rx_flush,
    output logic        tx_flush
);
    ctl_t q, d;

    logic             dlab;
    logic [7:0]       lsr_val;
    logic [7:0]       msr_val;
    logic [7:0]       iir_val;
    logic [2:0]       iir_id;
    logic [SRC_N-1:0] src_pend;
    logic [SRC_N-1:0] src_en;
    logic [SRC_N-1:0] src_req;
    logic             ier_wr, idfc_wr, lsr_rd, msr_rd, iir_rd;

    assign dlab     = q.lcr[7];
    assign tx_write = wr_en && (addr == OFS_DATA) && !dlab;
    assign tx_byte  = wr_data;
    assign rx_pop   = rd_en && (addr == OFS_DATA) && !dlab;
    assign ier_wr   = wr_en && (addr == OFS_ENA) && !dlab;
    assign idfc_wr  = wr_en && (addr == OFS_IDFC);
    assign rx_flush = idfc_wr && wr_data[1];
    assign tx_flush = idfc_wr && wr_data[2];
    assign lsr_rd   = rd_en && (addr == OFS_LSTAT);
    assign msr_rd   = rd_en && (addr == OFS_MSTAT);
    assign iir_rd   = rd_en && (addr == OFS_IDFC);

    sr_line_status #(.ERR_W(ERR_N)) u_lsr (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .clr_rd(lsr_rd),
        .rx_ready(rx_ready), .thr_empty(thr_empty), .tx_idle(tx_idle),
        .lsr(lsr_val)
    );

    sr_modem_status #(.LINES(4)) u_msr (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .clr_rd(msr_rd),
        .msr(msr_val)
    );

    // priority order: line error, receive data, transmit empty, modem change
    assign src_pend = {|msr_val[3:0], q.thre_pend, rx_ready, |lsr_val[4:1]};
    assign src_en   = {q.ier[3], q.ier[1], q.ier[0], q.ier[2]};
    assign src_req  = src_pend & src_en;

    sr_irq_prio #(.N(SRC_N)) u_prio (
        .req(src_req),
        .codes({ID_MSTAT, ID_TXEMP, ID_RXDAT, ID_LSTAT}),
        .idle_code(ID_NONE),
        .id(iir_id)
    );

    assign iir_val = {{2{q.fcr[0]}}, 3'b000, iir_id};

    // interrupt line from the enable mask, independent of the encoder
    assign irq = |(q.ier & {|msr_val[3:0], |lsr_val[4:1], q.thre_pend, rx_ready});

    always_comb begin
        logic thre_set, thre_clr;
        d = q;
        d.thr_empty_q = thr_empty;
        if (wr_en) begin
            case (addr)
                OFS_DATA:  if (dlab) d.div[7:0] = wr_data;
                OFS_ENA:   if (dlab) d.div[15:8] = wr_data;
                           else      d.ier = wr_data[SRC_N-1:0];
                OFS_IDFC:  d.fcr = {wr_data[7:3], 2'b00, wr_data[0]};
                OFS_LINE:  d.lcr = wr_data;
                OFS_MODEM: d.mcr = wr_data[5:0];
                default:   ;
            endcase
        end
        thre_set = (thr_empty && !q.thr_empty_q)
                 || (ier_wr && wr_data[1] && !q.ier[1] && thr_empty);
        thre_clr = tx_write || (iir_rd && (iir_id == ID_TXEMP));
        d.thre_pend = thre_set || (q.thre_pend && !thre_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q             <= '0;
            q.thr_empty_q <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            OFS_DATA:  rd_data = dlab ? q.div[7:0]  : rx_byte;
            OFS_ENA:   rd_data = dlab ? q.div[15:8] : {4'h0, q.ier};
            OFS_IDFC:  rd_data = iir_val;
            OFS_LINE:  rd_data = q.lcr;
            OFS_MODEM: rd_data = {2'b00, q.mcr};
            OFS_LSTAT: rd_data = lsr_val;
            OFS_MSTAT: rd_data = msr_val;
            default:   rd_data = 8'h00;
        endcase
    end

    assign divisor   = q.div;
    assign frame_cfg = q.lcr[6:0];
    assign modem_ctl = q.mcr;
    assign fifo_cfg  = q.fcr;
endmodule

// File: rtl/sr_regfile_chk.sv
module sr_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wr_data,
    input logic [3:0] err_evt,
    input logic [3:0] line_in,
    input logic       tx_write,
    input logic       rx_pop,
    input logic       dlab,
    input logic [6:0] frame_cfg,
    input logic [7:0] lsr_val,
    input logic [7:0] msr_val,
    input logic [7:0] iir_val,
    input logic       irq
);
    a_r3_bank_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
        dlab |-> (!tx_write && !rx_pop));

    a_r5_line_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3) |=> (frame_cfg == $past(wr_data[6:0])));

    a_r6_errors_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5 && err_evt == 4'h0) |=> (lsr_val[4:1] == 4'h0));

    a_r7_changes_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd6 && msr_val[7:4] == line_in) |=> (msr_val[3:0] == 4'h0));

    a_r8_idle_code_form: assert property (@(posedge clk) disable iff (!rst_n)
        iir_val[0] |-> (iir_val[2:1] == 2'b00));

    a_r10_irq_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir_val[0]);
endmodule

bind serial_regfile sr_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .err_evt(err_evt), .line_in(line_in),
    .tx_write(tx_write), .rx_pop(rx_pop), .dlab(dlab), .frame_cfg(frame_cfg),
    .lsr_val(lsr_val), .msr_val(msr_val), .iir_val(iir_val), .irq(irq)
);

// File: tb/serial_regfile_tb.sv
module serial_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq, tx_write, rx_pop, rx_flush, tx_flush;
    logic [7:0]  tx_byte, fifo_cfg;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_ready = 1'b0, thr_empty = 1'b1, tx_idle = 1'b1;
    logic [3:0]  err_evt = '0, line_in = '0;
    logic [15:0] divisor;
    logic [6:0]  frame_cfg;
    logic [5:0]  modem_ctl;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic seen_tx, seen_pop, seen_rxf, seen_txf, got_irq;
    logic [7:0] seen_byte, rv;

    always #2 clk = ~clk;

    serial_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .tx_write(tx_write),
        .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .thr_empty(thr_empty), .tx_idle(tx_idle), .err_evt(err_evt),
        .line_in(line_in), .divisor(divisor), .frame_cfg(frame_cfg),
        .modem_ctl(modem_ctl), .fifo_cfg(fifo_cfg), .rx_flush(rx_flush),
        .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wr_data = v; wr_en = 1'b1;
        #1;
        seen_tx = tx_write; seen_byte = tx_byte; seen_rxf = rx_flush; seen_txf = tx_flush;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        v = rd_data; seen_pop = rx_pop; got_irq = irq;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [2:0] exp_id(input logic [3:0] en);
        if (en[2])      return 3'b110;
        else if (en[0]) return 3'b100;
        else if (en[1]) return 3'b010;
        else if (en[3]) return 3'b000;
        return 3'b001;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog got hang exp finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(3'd2, rv); chk("R1 iir", rv, 8'h01); chk("R1 irq", got_irq, 0);
        rd(3'd3, rv); chk("R1 lcr", rv, 8'h00);
        rd(3'd1, rv); chk("R1 ier", rv, 8'h00);
        rd(3'd4, rv); chk("R1 mcr", rv, 8'h00);
        chk("R1 divisor", divisor, 16'h0000);
        chk("R1 fifo", fifo_cfg, 8'h00);
        rd(3'd5, rv); chk("R6 lsr idle", rv, 8'h60);
        rd(3'd6, rv); chk("R7 msr idle", rv, 8'h00);

        // R5 sweeps
        for (int v = 0; v < 128; v++) begin
            wr(3'd3, v[7:0]); rd(3'd3, rv);
            chk("R5 lcr read", rv, v[7:0]); chk("R5 frame_cfg", frame_cfg, v[6:0]);
        end
        for (int v = 0; v < 256; v++) begin
            wr(3'd4, v[7:0]); rd(3'd4, rv);
            chk("R5 mcr read", rv, {2'b00, v[5:0]}); chk("R5 modem_ctl", modem_ctl, v[5:0]);
        end
        wr(3'd3, 8'h03);

        // R2 enable register
        for (int v = 0; v < 256; v += 17) begin
            wr(3'd1, v[7:0]); rd(3'd1, rv);
            chk("R2 ier read", rv, {4'h0, v[3:0]});
        end
        wr(3'd1, 8'h00);

        // R3 divisor bank
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34); chk("R3 no tx_write", seen_tx, 0);
        wr(3'd1, 8'h12);
        chk("R3 divisor", divisor, 16'h1234);
        rd(3'd0, rv); chk("R3 dll read", rv, 8'h34); chk("R3 no rx_pop", seen_pop, 0);
        rd(3'd1, rv); chk("R3 dlm read", rv, 8'h12);
        for (int i = 0; i < 256; i += 5) begin
            wr(3'd0, i[7:0]); wr(3'd1, ~i[7:0]);
            chk("R3 divisor sweep", divisor, {~i[7:0], i[7:0]});
        end
        wr(3'd3, 8'h03);
        rd(3'd1, rv); chk("R3 ier untouched", rv, 8'h00);

        // R2 data path
        rx_byte = 8'hA5;
        rd(3'd0, rv); chk("R2 rx read", rv, 8'hA5); chk("R2 rx_pop", seen_pop, 1);
        wr(3'd0, 8'h5A); chk("R2 tx_write", seen_tx, 1); chk("R2 tx_byte", seen_byte, 8'h5A);

        // R4 FIFO control / identity split
        wr(3'd2, 8'hC7);
        chk("R4 flush rx", seen_rxf, 1); chk("R4 flush tx", seen_txf, 1);
        chk("R4 fifo_cfg", fifo_cfg, 8'hC1);
        rd(3'd2, rv); chk("R4 iir fifo on", rv, 8'hC1);
        wr(3'd2, 8'h00);
        chk("R4 no flush", {seen_rxf, seen_txf}, 2'b00);
        rd(3'd2, rv); chk("R4 iir fifo off", rv, 8'h01);

        // R11 unused offset
        wr(3'd7, 8'hFF);
        rd(3'd7, rv); chk("R11 read zero", rv, 8'h00);
        rd(3'd3, rv); chk("R11 lcr kept", rv, 8'h03);
        rd(3'd4, rv); chk("R11 mcr kept", rv, 8'h3F);

        // R6 sticky errors
        for (int k = 0; k < 4; k++) begin
            err_evt = 4'b1 << k; tick(); err_evt = '0;
            rd(3'd5, rv); chk("R6 error latched", rv, 8'h60 | (8'h02 << k));
            rd(3'd5, rv); chk("R6 error cleared", rv, 8'h60);
        end
        @(negedge clk); addr = 3'd5; rd_en = 1'b1; err_evt = 4'b0001;
        #1 rv = rd_data;
        @(posedge clk); #1 rd_en = 1'b0; err_evt = '0;
        chk("R6 same-cycle read old", rv, 8'h60);
        rd(3'd5, rv); chk("R6 same-cycle event kept", rv, 8'h62);
        rd(3'd5, rv); chk("R6 cleared after", rv, 8'h60);
        rx_ready = 1'b1; thr_empty = 1'b0; tx_idle = 1'b0;
        rd(3'd5, rv); chk("R6 live bits", rv, 8'h01);
        rx_ready = 1'b0; thr_empty = 1'b1; tx_idle = 1'b1;
        tick();

        // R7 modem status
        line_in = 4'b0101; tick();
        rd(3'd6, rv); chk("R7 msr change", rv, 8'h55);
        rd(3'd6, rv); chk("R7 msr cleared", rv, 8'h50);

        // R8/R10 priority sweep with all sources pending
        err_evt = 4'b0001; line_in = 4'b0100; rx_ready = 1'b1; tick(); err_evt = '0;
        for (int v = 0; v < 16; v++) begin
            wr(3'd1, 8'h00); wr(3'd1, v[7:0]);
            rd(3'd2, rv);
            chk("R8 priority id", rv, {5'b0, exp_id(v[3:0])});
            chk("R10 irq", got_irq, (v != 0));
        end
        wr(3'd1, 8'h0F);
        rd(3'd5, rv); chk("R6 lsr with data", rv, 8'h63);
        rd(3'd2, rv); chk("R8 rx data next", rv, 8'h04);
        rx_ready = 1'b0; tick();
        rd(3'd2, rv); chk("R9 thre reported", rv, 8'h02);
        rd(3'd2, rv); chk("R9 thre cleared by id read", rv, 8'h00);
        rd(3'd6, rv);
        rd(3'd2, rv); chk("R8 none pending", rv, 8'h01); chk("R10 irq low", got_irq, 0);

        // R9 transmit empty sources
        wr(3'd1, 8'h00); wr(3'd1, 8'h02);
        rd(3'd2, rv); chk("R9 armed by enable", rv, 8'h02);
        wr(3'd1, 8'h00); wr(3'd1, 8'h02);
        wr(3'd0, 8'h11);
        rd(3'd2, rv); chk("R9 cleared by tx write", rv, 8'h01);
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        rd(3'd2, rv); chk("R9 set by empty rise", rv, 8'h02); chk("R10 irq high", got_irq, 1);
        wr(3'd1, 8'h00);
        rd(3'd2, rv); chk("R10 masked", rv, 8'h01); chk("R10 irq masked", got_irq, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule